// File: doc/BRIEF.md
# Sequential Polar Code Encoder

This block turns one extended input vector U of length N = 2^LOG2N into its polar codeword X = U times the n-fold Kronecker power of the 2x2 lower-triangular kernel [[1,0],[1,1]], over GF(2). U arrives one bit per clock, index 0 first, qualified by a valid strobe. A static frozen-position mask forces the bits at frozen indices to zero, whatever the input carries. The caller supplies both the choice of reliable positions and the data bits.

Internally an N-bit shift-and-accumulate register takes each accepted bit. A bit enters at every register position whose control bit is set, and the value moves one position along. An N-bit row generator steps through the kernel-power rows by a simple neighbour-XOR recurrence, so no row table is stored. After the N-th accepted bit the codeword stands in parallel on the output. A one-cycle done pulse marks it, and input is refused until the caller takes the word or restarts.

Top module: `polar_seq_encoder`

## Requirements
- R1: While reset is asserted and in the cycle after it, done is 0, in_ready is 1 and code_word is all zero.
- R2: After N accepted bits, code_word bit j equals the XOR of the effective input bits u_i over every index i with (i AND j) == j, for i and j in 0..N-1. Input bit index 0 is the first one accepted after reset, start or take.
- R3: A bit is accepted only in a cycle with in_valid high, in_ready high and start low. Cycles without acceptance do not advance the index and leave code_word unchanged, whatever in_bit carries.
- R4: When frozen_mask bit i is 1, input index i is encoded as 0 regardless of in_bit.
- R5: done is high for exactly one cycle, the cycle after the N-th bit is accepted.
- R6: From the cycle after the N-th accepted bit, in_ready is 0 and code_word stays stable. in_valid bits offered in that time are ignored until take or start.
- R7: take while in_ready is 0 returns in_ready to 1 in the next cycle with code_word cleared to zero and the index back at 0. take while a frame is still being collected has no effect.
- R8: start at any time clears the register, the row generator and the index. The cycle after start shows in_ready 1, done 0 and code_word zero. A bit offered in the same cycle as start is discarded.
- R9: The same behaviour holds for every LOG2N from 1 to 10. Other values stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Restart pulse; abandons any frame in progress |
| take | input | 1 | Caller has consumed the held codeword |
| frozen_mask | input | N | Bit i set marks input index i as frozen |
| in_valid | input | 1 | in_bit carries the next input bit |
| in_bit | input | 1 | Serial input bit |
| in_ready | output | 1 | Block can accept a bit |
| done | output | 1 | One-cycle pulse when the codeword is complete |
| code_word | output | N | Codeword, bit j is x_j |

## Verification
Restart and bit acceptance can land in the same cycle. The bench raises start together with a valid 1 bit part-way through a frame, then sends a fresh random frame. That frame matches the reference only if the colliding bit was dropped and indexing restarted at 0. A second collision is a take pulse during collection and the release of a held word: take is pulsed in an idle cycle mid-frame, and the finished word must still match the full reference product.

// File: rtl/polar_enc_pkg.sv
`timescale 1ns/1ps
package polar_enc_pkg;
   localparam int unsigned MIN_LOG2N = 1;
   localparam int unsigned MAX_LOG2N = 10;

   function automatic bit log2n_ok(input int unsigned l);
      return (l >= MIN_LOG2N) && (l <= MAX_LOG2N);
   endfunction
endpackage

// File: rtl/polar_row_gen.sv
`timescale 1ns/1ps
// Steps through the rows of the kernel power: slot 0 is forced to 1,
// every other slot folds in its lower neighbour on each step.
module polar_row_gen #(
   parameter int unsigned LOG2N = 3,
   localparam int unsigned N = 1 << LOG2N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   output logic [N-1:0] row
);
   localparam logic [N-1:0] ROW0 = {{(N-1){1'b0}}, 1'b1};

   for (genvar k = 0; k < N; k++) begin : g_slot
      if (k == 0) begin : g_lead
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     row[k] <= ROW0[k];
            else if (clear) row[k] <= ROW0[k];
            else if (step)  row[k] <= 1'b1;
         end
      end else begin : g_fold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     row[k] <= ROW0[k];
            else if (clear) row[k] <= ROW0[k];
            else if (step)  row[k] <= row[k] ^ row[k-1];
         end
      end
   end
endmodule

// File: rtl/polar_sx_reg.sv
`timescale 1ns/1ps
// Shift-and-accumulate register: each slot takes its lower neighbour
// XOR the gated input bit; slot 0 takes the gated bit alone.
module polar_sx_reg #(
   parameter int unsigned LOG2N = 3,
   localparam int unsigned N = 1 << LOG2N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         step,
   input  logic         din,
   input  logic [N-1:0] row,
   output logic [N-1:0] acc
);
   logic [N-1:0] gated;

   for (genvar k = 0; k < N; k++) begin : g_pos
      assign gated[k] = din & row[k];
      if (k == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     acc[k] <= 1'b0;
            else if (clear) acc[k] <= 1'b0;
            else if (step)  acc[k] <= gated[k];
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     acc[k] <= 1'b0;
            else if (clear) acc[k] <= 1'b0;
            else if (step)  acc[k] <= acc[k-1] ^ gated[k];
         end
      end
   end
endmodule

// File: rtl/polar_frame_seq.sv
`timescale 1ns/1ps
// Frame sequencer: input index, hold state after the last bit, done pulse.
module polar_frame_seq #(
   parameter int unsigned LOG2N = 3,
   localparam int unsigned N = 1 << LOG2N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  logic             in_valid,
   output logic             accept,
   output logic             restart,
   output logic [LOG2N-1:0] idx,
   output logic             hold,
   output logic             done
);
   localparam logic [LOG2N-1:0] LAST = LOG2N'(N - 1);

   assign restart = start | (take & hold);
   assign accept  = in_valid & ~hold & ~start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx  <= '0;
         hold <= 1'b0;
         done <= 1'b0;
      end else if (restart) begin
         idx  <= '0;
         hold <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (idx == LAST) begin
               idx  <= '0;
               hold <= 1'b1;
               done <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/polar_seq_encoder.sv
`timescale 1ns/1ps
module polar_seq_encoder #(
   parameter int unsigned LOG2N = 3,
   localparam int unsigned N = 1 << LOG2N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         take,
   input  logic [N-1:0] frozen_mask,
   input  logic         in_valid,
   input  logic         in_bit,
   output logic         in_ready,
   output logic         done,
   output logic [N-1:0] code_word
);
   import polar_enc_pkg::*;

   if (!log2n_ok(LOG2N)) begin : g_bad_size
      $error("polar_seq_encoder: LOG2N out of supported range");
   end

   logic             accept;
   logic             restart;
   logic             hold;
   logic [LOG2N-1:0] idx;
   logic             eff_bit;
   logic [N-1:0]     row;
   logic [N-1:0]     acc;

   polar_frame_seq #(.LOG2N(LOG2N)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .take     (take),
      .in_valid (in_valid),
      .accept   (accept),
      .restart  (restart),
      .idx      (idx),
      .hold     (hold),
      .done     (done)
   );

   assign eff_bit = in_bit & ~frozen_mask[idx];

   polar_row_gen #(.LOG2N(LOG2N)) u_rows (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .step  (accept),
      .row   (row)
   );

   polar_sx_reg #(.LOG2N(LOG2N)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (restart),
      .step  (accept),
      .din   (eff_bit),
      .row   (row),
      .acc   (acc)
   );

   // Slot k ends the frame holding codeword bit N-1-k.
   for (genvar j = 0; j < N; j++) begin : g_out
      assign code_word[j] = acc[N-1-j];
   end

   assign in_ready = ~hold;
endmodule

// File: rtl/polar_seq_encoder_chk.sv
`timescale 1ns/1ps
module polar_seq_encoder_chk #(
   parameter int unsigned LOG2N = 3,
   localparam int unsigned N = 1 << LOG2N
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         take,
   input logic         in_valid,
   input logic         in_ready,
   input logic         done,
   input logic [N-1:0] code_word
);
   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (!done && in_ready && code_word == '0));

   p_idle_keeps_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !start && !take) |=> $stable(code_word));

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);

   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && !start && !take) |=> (!in_ready && $stable(code_word)));

   p_take_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && take) |=> (in_ready && !done && code_word == '0));

   p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (in_ready && !done && code_word == '0));
endmodule

bind polar_seq_encoder polar_seq_encoder_chk #(.LOG2N(LOG2N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .take      (take),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .done      (done),
   .code_word (code_word)
);

// File: tb/polar_seq_encoder_tb.sv
`timescale 1ns/1ps
module polar_seq_encoder_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int sel = 0;       // 0: N=8 instance, 1: N=32 instance
   int len = 8;

   logic        d_start = 1'b0, d_take = 1'b0, d_valid = 1'b0, d_bit = 1'b0;
   logic [31:0] d_mask = '0;

   logic        a_ready, a_done;
   logic [7:0]  a_code;
   logic        b_ready, b_done;
   logic [31:0] b_code;

   polar_seq_encoder #(.LOG2N(3)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .start(d_start & (sel == 0)), .take(d_take & (sel == 0)),
      .frozen_mask(d_mask[7:0]),
      .in_valid(d_valid & (sel == 0)), .in_bit(d_bit),
      .in_ready(a_ready), .done(a_done), .code_word(a_code)
   );

   polar_seq_encoder #(.LOG2N(5)) u_dut_w (
      .clk(clk), .rst_n(rst_n),
      .start(d_start & (sel == 1)), .take(d_take & (sel == 1)),
      .frozen_mask(d_mask),
      .in_valid(d_valid & (sel == 1)), .in_bit(d_bit),
      .in_ready(b_ready), .done(b_done), .code_word(b_code)
   );

   logic        o_ready, o_done;
   logic [31:0] o_code;
   assign o_ready = (sel == 1) ? b_ready : a_ready;
   assign o_done  = (sel == 1) ? b_done  : a_done;
   assign o_code  = (sel == 1) ? b_code  : {24'b0, a_code};

   function automatic logic [31:0] ref_enc(logic [31:0] u, logic [31:0] m, int n);
      logic [31:0] x = '0;
      logic [31:0] e = u & ~m;
      for (int j = 0; j < n; j++)
         for (int i = 0; i < n; i++)
            if ((i & j) == j) x[j] = x[j] ^ e[i];
      return x;
   endfunction

   function automatic logic [31:0] lenmask(int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s N=%0d act=%h exp=%h", req, len, act, exp);
      end
   endtask

   // Sends len bits; optional idle gaps; optional take pulse before bit take_at.
   task automatic send_frame(logic [31:0] u, bit gaps, int take_at);
      for (int i = 0; i < len; i++) begin
         if (i == take_at) begin
            d_valid = 1'b0; d_take = 1'b1; d_bit = 1'b1;
            @(negedge clk);
            d_take = 1'b0;
         end
         if (gaps) begin
            int g = int'($urandom_range(0, 2));
            for (int k = 0; k < g; k++) begin
               d_valid = 1'b0; d_bit = 1'($urandom);
               @(negedge clk);
            end
         end
         d_valid = 1'b1; d_bit = u[i];
         @(negedge clk);
      end
      d_valid = 1'b0;
   endtask

   task automatic run_check(logic [31:0] u, logic [31:0] m, bit gaps, int take_at, string req);
      logic [31:0] exp;
      d_mask = m;
      exp = ref_enc(u, m, len);
      send_frame(u, gaps, take_at);
      chk({req, " codeword"}, o_code, exp);
      chk("R5 done pulse", {31'b0, o_done}, 32'd1);
      chk("R6 ready low after frame", {31'b0, o_ready}, 32'd0);
      @(negedge clk);
      chk("R5 done falls", {31'b0, o_done}, 32'd0);
      d_valid = 1'b1; d_bit = 1'b1;
      @(negedge clk);
      d_bit = 1'b0;
      @(negedge clk);
      d_valid = 1'b0;
      chk("R6 held word ignores input", o_code, exp);
      chk("R6 ready stays low", {31'b0, o_ready}, 32'd0);
      d_take = 1'b1;
      @(negedge clk);
      d_take = 1'b0;
      chk("R7 take releases ready", {31'b0, o_ready}, 32'd1);
      chk("R7 take clears word", o_code, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      for (int s = 0; s < 2; s++) begin
         sel = s; len = (s == 0) ? 8 : 32;
         #1;
         chk("R1 reset done", {31'b0, o_done}, 32'd0);
         chk("R1 reset ready", {31'b0, o_ready}, 32'd1);
         chk("R1 reset word", o_code, 32'd0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      for (int s = 0; s < 2; s++) begin
         logic [31:0] lm;
         sel = s; len = (s == 0) ? 8 : 32;
         lm = lenmask(len);
         @(negedge clk);
         // R9: same checks across both sizes
         run_check(32'd0, 32'd0, 1'b0, -1, "R2 all-zero");
         run_check(lm, 32'd0, 1'b0, -1, "R2 all-one");
         run_check(32'd1 << (len - 1), 32'd0, 1'b0, -1, "R2 last index only");
         run_check(32'd1, 32'd0, 1'b0, -1, "R2 first index only");
         run_check(lm, $urandom & lm, 1'b0, -1, "R4 frozen forced");
         run_check(lm, lm, 1'b0, -1, "R4 all frozen");
         for (int r = 0; r < 6; r++)
            run_check($urandom & lm, $urandom & lm, 1'b1, -1, "R3 gapped random");
         run_check($urandom & lm, 32'd0, 1'b1, len / 2, "R7 take mid-frame ignored");

         // R8: start collides with a valid bit mid-frame
         d_mask = 32'd0;
         for (int i = 0; i < 3; i++) begin
            d_valid = 1'b1; d_bit = 1'b1;
            @(negedge clk);
         end
         d_start = 1'b1; d_valid = 1'b1; d_bit = 1'b1;
         @(negedge clk);
         d_start = 1'b0; d_valid = 1'b0;
         chk("R8 start clears word", o_code, 32'd0);
         chk("R8 start ready", {31'b0, o_ready}, 32'd1);
         run_check($urandom & lm, 32'd0, 1'b0, -1, "R8 frame after start");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule